// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. A prescaler divides the input clock into sub-second steps, and a free-running sub-second counter carries into a chain of packed-BCD calendar fields. The chain holds seconds, minutes, hours, a weekday, a day of month, a month and a four-digit year. The fields roll over by calendar rules, including month lengths and leap Februaries.

Software reaches the block through a flat register port. There is one synchronous write strobe and a combinational read mux. Two control registers provide the following. Software can start and stop counting and clear the prescaler. It can request a rounding to the nearest minute. A carry flag records every advance of the seconds field. The usual way to set the time is to stop counting with the prescaler cleared, write the fields, and then start again. After reading the time across several registers, software checks the carry flag. If the flag is set, a rollover happened during the read and software reads the time again. The flag can also raise an interrupt.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset, the block reads 00:00:00 with weekday 00, day 01, month 01 and year 0x2000. The sub-second counter and both control registers read 0, and carry_irq is 0.
- R2: The register addresses are 0 for the sub-second counter, 1 to 6 for second, minute, hour, weekday, day of month and month (8-bit BCD each), 7 for the year, 8 for control A and 9 for control B. The year is 16 bits, with the BCD century in bits 15:8 and the BCD year in the century in bits 7:0. Unused upper read bits are 0.
- R3: While running, the sub-second counter advances once every DIV clocks. The seconds field advances when that counter wraps past its maximum, which is once every DIV*2^SUB_BITS clocks.
- R4: Seconds and minutes roll from 59 to 00 and carry onward. Hours roll from 23 to 00 and advance both the day and the weekday. The weekday wraps from 06 to 00.
- R5: The last day is 30 for months 04, 06, 09 and 11. It is 31 for the other months, except month 02. Month 02 ends at 29 when the low year byte is divisible by 4, and at 28 otherwise. The day then returns to 01. Month 12 rolls to 01 and advances the year. Year 99 rolls to 00 and advances the century. Century 99 rolls to 00.
- R6: In control B, bit 0 is start, and nothing counts while it is 0. Bit 3 is an enable flag that is stored and read back but does not affect counting. Bits 1 and 2 always read 0.
- R7: Writing control B with bit 1 set clears the prescaler and the sub-second counter at that edge, and no seconds advance happens at that edge. The next seconds advance comes one full second period later.
- R8: A write to a time field replaces it at the next edge. That write takes priority over any advance of the same field in that cycle. After start is set, counting continues from the written values.
- R9: Writing control B with bit 2 set applies an adjustment. If seconds are below 30, they become 00. Otherwise seconds become 00 and the minute advances, with carries. The adjustment takes priority over a seconds advance in the same cycle.
- R10: The carry flag (control A bit 7) is set on every seconds advance. Writing control A with bit 7 at 0 clears the flag, and writing it with bit 7 at 1 leaves the flag unchanged. If a seconds advance and a clearing write happen at the same edge, the flag is set.
- R11: carry_irq is high exactly when the carry flag and the interrupt enable (control A bit 4) are both 1.
- R12: A value with an illegal BCD digit written to a time field is stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench drives the cascade through its deepest paths. These are a New Year crossing, a century wrap, a wrap of year 9999, leap and non-leap Februaries and a 30-day month. A wrong month-length table or a wrong leap test would give a day such as 02-30 or skip 02-29. A missing carry would leave the higher fields frozen. The adjustment is tested on both sides of 30 seconds, including a carry into the hour, to catch rounding in the wrong direction. The bench also clears the prescaler in the middle of a second and clears the carry flag on the same edge as a seconds advance. A design with the wrong priority there would lose the rollover indication or shift the second boundary.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 16;
    localparam int CF_BIT    = 7;
    localparam int CIE_BIT   = 4;
    localparam int EN_BIT    = 3;
    localparam int ADJ_BIT   = 2;
    localparam int PRST_BIT  = 1;
    localparam int START_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_SUB   = 4'd0,
        RA_SEC   = 4'd1,
        RA_MIN   = 4'd2,
        RA_HOUR  = 4'd3,
        RA_WDAY  = 4'd4,
        RA_MDAY  = 4'd5,
        RA_MONTH = 4'd6,
        RA_YEAR  = 4'd7,
        RA_CTRLA = 4'd8,
        RA_CTRLB = 4'd9
    } rtc_reg_e;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  month;
        logic [7:0]  mday;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  minute;
        logic [7:0]  second;
    } rtc_time_t;

    localparam rtc_time_t TIME_AT_RESET = '{year: 16'h2000, month: 8'h01, mday: 8'h01,
                                            wday: 8'h00, hour: 8'h00, minute: 8'h00,
                                            second: 8'h00};

    // Plain nibble increment; callers handle their own wrap points.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Two-digit BCD divisible by 4: even tens need 0/4/8, odd tens need 2/6.
    function automatic logic yy_is_leap(input logic [7:0] yy);
        if (yy[4]) return (yy[3:0] == 4'd2) || (yy[3:0] == 4'd6);
        return (yy[3:0] == 4'd0) || (yy[3:0] == 4'd4) || (yy[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_mday(input logic [7:0] mon, input logic [7:0] yy);
        case (mon)
            8'h02:                      return yy_is_leap(yy) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t bump_day(input rtc_time_t t);
        rtc_time_t n = t;
        n.wday = (t.wday == 8'h06) ? 8'h00 : bcd_inc(t.wday);
        if (t.mday != last_mday(t.month, t.year[7:0])) begin
            n.mday = bcd_inc(t.mday);
        end else begin
            n.mday = 8'h01;
            if (t.month != 8'h12) begin
                n.month = bcd_inc(t.month);
            end else begin
                n.month = 8'h01;
                if (t.year[7:0] != 8'h99) begin
                    n.year[7:0] = bcd_inc(t.year[7:0]);
                end else begin
                    n.year[7:0]  = 8'h00;
                    n.year[15:8] = (t.year[15:8] == 8'h99) ? 8'h00 : bcd_inc(t.year[15:8]);
                end
            end
        end
        return n;
    endfunction

    function automatic rtc_time_t bump_minute(input rtc_time_t t);
        rtc_time_t n = t;
        if (t.minute != 8'h59) begin
            n.minute = bcd_inc(t.minute);
        end else begin
            n.minute = 8'h00;
            if (t.hour != 8'h23) begin
                n.hour = bcd_inc(t.hour);
            end else begin
                n.hour = 8'h00;
                n = bump_day(n);
            end
        end
        return n;
    endfunction

    function automatic rtc_time_t bump_second(input rtc_time_t t);
        rtc_time_t n = t;
        if (t.second != 8'h59) begin
            n.second = bcd_inc(t.second);
        end else begin
            n.second = 8'h00;
            n = bump_minute(n);
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int DIV      = 256,
    parameter int SUB_BITS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                clear,
    output logic [SUB_BITS-1:0] sub_cnt,
    output logic                sec_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] DIV_LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;
    logic          div_wrap;

    assign div_wrap = (div_q == DIV_LAST);
    assign sec_tick = run && !clear && div_wrap && (sub_cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q   <= '0;
            sub_cnt <= '0;
        end else if (run) begin
            if (div_wrap) begin
                div_q   <= '0;
                sub_cnt <= sub_cnt + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_chain.sv
`timescale 1ns/1ps
module rtc_calendar_chain
    import rtc_cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 adjust,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output rtc_time_t            cur
);
    rtc_time_t nxt;

    always_comb begin
        nxt = cur;
        if (adjust) begin
            if (cur.second >= 8'h30) nxt = bump_minute(cur);
            nxt.second = 8'h00;
        end else if (tick) begin
            nxt = bump_second(cur);
        end
        if (wr_en) begin
            case (rtc_reg_e'(wr_addr))
                RA_SEC:   nxt.second = wr_data[7:0];
                RA_MIN:   nxt.minute = wr_data[7:0];
                RA_HOUR:  nxt.hour   = wr_data[7:0];
                RA_WDAY:  nxt.wday   = wr_data[7:0];
                RA_MDAY:  nxt.mday   = wr_data[7:0];
                RA_MONTH: nxt.month  = wr_data[7:0];
                RA_YEAR:  nxt.year   = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= TIME_AT_RESET;
        else     cur <= nxt;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV      = 256,
    parameter int SUB_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic              carry_irq
);
    logic                wr_ctrla, wr_ctrlb, prst_wr, adj_wr;
    logic                cf_q, cie_q, en_q, start_q;
    logic                sec_tick;
    logic [SUB_BITS-1:0] sub_cnt;
    rtc_time_t           cur_time;

    assign wr_ctrla = wr_en && (wr_addr == RA_CTRLA);
    assign wr_ctrlb = wr_en && (wr_addr == RA_CTRLB);
    assign prst_wr  = wr_ctrlb && wr_data[PRST_BIT];
    assign adj_wr   = wr_ctrlb && wr_data[ADJ_BIT];

    rtc_prescaler #(.DIV(DIV), .SUB_BITS(SUB_BITS)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (start_q),
        .clear    (prst_wr),
        .sub_cnt  (sub_cnt),
        .sec_tick (sec_tick)
    );

    rtc_calendar_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .tick    (sec_tick),
        .adjust  (adj_wr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur     (cur_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cf_q    <= 1'b0;
            cie_q   <= 1'b0;
            en_q    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            if (sec_tick)                          cf_q <= 1'b1;
            else if (wr_ctrla && !wr_data[CF_BIT]) cf_q <= 1'b0;
            if (wr_ctrla) cie_q <= wr_data[CIE_BIT];
            if (wr_ctrlb) begin
                en_q    <= wr_data[EN_BIT];
                start_q <= wr_data[START_BIT];
            end
        end
    end

    assign carry_irq = cf_q & cie_q;

    always_comb begin
        rd_data = '0;
        case (rtc_reg_e'(rd_addr))
            RA_SUB:   rd_data[SUB_BITS-1:0] = sub_cnt;
            RA_SEC:   rd_data[7:0] = cur_time.second;
            RA_MIN:   rd_data[7:0] = cur_time.minute;
            RA_HOUR:  rd_data[7:0] = cur_time.hour;
            RA_WDAY:  rd_data[7:0] = cur_time.wday;
            RA_MDAY:  rd_data[7:0] = cur_time.mday;
            RA_MONTH: rd_data[7:0] = cur_time.month;
            RA_YEAR:  rd_data      = cur_time.year;
            RA_CTRLA: begin
                rd_data[CF_BIT]  = cf_q;
                rd_data[CIE_BIT] = cie_q;
            end
            RA_CTRLB: begin
                rd_data[EN_BIT]    = en_q;
                rd_data[START_BIT] = start_q;
            end
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
`timescale 1ns/1ps
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
#(
    parameter int SUB_BITS = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                prst_wr,
    input logic                adj_wr,
    input logic                run,
    input logic [SUB_BITS-1:0] sub_cnt,
    input rtc_time_t           cur_time,
    input logic                carry_flag
);
    // R6
    sub_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !prst_wr) |=> $stable(sub_cnt));

    // R6
    time_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(cur_time));

    // R7
    presc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        prst_wr |=> (sub_cnt == '0));

    // R9
    adjust_zero_chk: assert property (@(posedge clk) disable iff (rst)
        adj_wr |=> (cur_time.second == 8'h00));

    // R10
    cf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carry_flag) |-> $past(run));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.SUB_BITS(SUB_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .prst_wr    (prst_wr),
    .adj_wr     (adj_wr),
    .run        (start_q),
    .sub_cnt    (sub_cnt),
    .cur_time   (cur_time),
    .carry_flag (cf_q)
);

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
    localparam int DIV  = 2;
    localparam int SUBB = 2;
    localparam int SUBN = 1 << SUBB;
    localparam int PER  = DIV * SUBN;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        carry_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rtc_calendar_core #(.DIV(DIV), .SUB_BITS(SUBB)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .carry_irq(carry_irq)
    );

    always #2 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_sec, m_min, m_hour, m_wday, m_day, m_mon;
    logic [15:0] m_year;
    int          m_presc, m_sub;
    bit          m_cf, m_cie, m_en, m_start;

    function automatic int bin(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int days_in(input logic [7:0] mon, input logic [7:0] yy);
        case (bin(mon))
            2: return (bin(yy) % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction

    task automatic m_day_step();
        m_wday = (bin(m_wday) == 6) ? 8'h00 : bcd(bin(m_wday) + 1);
        if (bin(m_day) < days_in(m_mon, m_year[7:0])) m_day = bcd(bin(m_day) + 1);
        else begin
            m_day = 8'h01;
            if (bin(m_mon) < 12) m_mon = bcd(bin(m_mon) + 1);
            else begin
                m_mon = 8'h01;
                if (bin(m_year[7:0]) < 99) m_year[7:0] = bcd(bin(m_year[7:0]) + 1);
                else begin
                    m_year[7:0]  = 8'h00;
                    m_year[15:8] = (bin(m_year[15:8]) < 99) ? bcd(bin(m_year[15:8]) + 1) : 8'h00;
                end
            end
        end
    endtask
    task automatic m_minute_step();
        if (bin(m_min) < 59) m_min = bcd(bin(m_min) + 1);
        else begin
            m_min = 8'h00;
            if (bin(m_hour) < 23) m_hour = bcd(bin(m_hour) + 1);
            else begin m_hour = 8'h00; m_day_step(); end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_day = 8'h01; m_mon = 8'h01;
            m_year = 16'h2000; m_presc = 0; m_sub = 0;
            m_cf = 0; m_cie = 0; m_en = 0; m_start = 0;
        end else begin
            bit wa, wb, prst, adj, tick;
            wa   = wr_en && wr_addr == 4'd8;
            wb   = wr_en && wr_addr == 4'd9;
            prst = wb && wr_data[1];
            adj  = wb && wr_data[2];
            tick = m_start && !prst && m_presc == DIV - 1 && m_sub == SUBN - 1;
            if (prst) begin m_presc = 0; m_sub = 0; end
            else if (m_start) begin
                if (m_presc == DIV - 1) begin m_presc = 0; m_sub = (m_sub + 1) % SUBN; end
                else m_presc++;
            end
            if (adj) begin
                if (bin(m_sec) >= 30) m_minute_step();
                m_sec = 8'h00;
            end else if (tick) begin
                if (bin(m_sec) < 59) m_sec = bcd(bin(m_sec) + 1);
                else begin m_sec = 8'h00; m_minute_step(); end
            end
            if (wr_en) case (wr_addr)
                4'd1: m_sec  = wr_data[7:0];
                4'd2: m_min  = wr_data[7:0];
                4'd3: m_hour = wr_data[7:0];
                4'd4: m_wday = wr_data[7:0];
                4'd5: m_day  = wr_data[7:0];
                4'd6: m_mon  = wr_data[7:0];
                4'd7: m_year = wr_data;
                default: ;
            endcase
            if (tick) m_cf = 1;
            else if (wa && !wr_data[7]) m_cf = 0;
            if (wa) m_cie = wr_data[4];
            if (wb) begin m_en = wr_data[3]; m_start = wr_data[0]; end
        end
    end

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return 16'(m_sub);
            4'd1: return {8'h00, m_sec};
            4'd2: return {8'h00, m_min};
            4'd3: return {8'h00, m_hour};
            4'd4: return {8'h00, m_wday};
            4'd5: return {8'h00, m_day};
            4'd6: return {8'h00, m_mon};
            4'd7: return m_year;
            4'd8: return {8'h00, m_cf, 2'b00, m_cie, 4'h0};
            4'd9: return {12'h000, m_en, 2'b00, m_start};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R3";
            4'd1, 4'd2, 4'd3, 4'd4: return "R4";
            4'd5, 4'd6, 4'd7: return "R5";
            4'd8: return "R10";
            4'd9: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the reference every clock, after the edge settles
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            check(tag_of(rd_addr), rd_data, m_read(rd_addr));
            check("R11", {15'b0, carry_irq}, {15'b0, m_cf & m_cie});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_addr = (rd_addr == 4'd9) ? 4'd0 : rd_addr + 4'd1;
        end
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        @(negedge clk);
        #1;
        check(tag, {15'b0, carry_irq}, {15'b0, exp});
    endtask

    task automatic set_time(input logic [15:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] w, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(4'd9, 16'h0002);
        wr(4'd1, {8'h00, s});
        wr(4'd2, {8'h00, mi});
        wr(4'd3, {8'h00, h});
        wr(4'd4, {8'h00, w});
        wr(4'd5, {8'h00, d});
        wr(4'd6, {8'h00, mo});
        wr(4'd7, y);
    endtask

    task automatic run_secs(input int n);
        wr(4'd9, 16'h0009);
        idle(PER * n + 2);
        wr(4'd9, 16'h0008);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 register addresses
        rd_chk(4'd0, 16'h0000, "R1");
        rd_chk(4'd1, 16'h0000, "R1");
        rd_chk(4'd5, 16'h0001, "R1");
        rd_chk(4'd6, 16'h0001, "R1");
        rd_chk(4'd7, 16'h2000, "R1 R2");
        rd_chk(4'd8, 16'h0000, "R1");
        rd_chk(4'd9, 16'h0000, "R1");
        irq_chk(1'b0, "R1");

        // R3 sub-second counter rate
        wr(4'd9, 16'h0002);
        wr(4'd9, 16'h0001);
        idle(4);
        rd_chk(4'd0, 16'h0002, "R3");
        wr(4'd9, 16'h0000);

        // R4 R5 R8 New Year crossing over two seconds
        set_time(16'h2023, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h58);
        rd_chk(4'd1, 16'h0058, "R8");
        run_secs(2);
        rd_chk(4'd1, 16'h0000, "R4");
        rd_chk(4'd2, 16'h0000, "R4");
        rd_chk(4'd3, 16'h0000, "R4");
        rd_chk(4'd4, 16'h0000, "R4");
        rd_chk(4'd5, 16'h0001, "R5");
        rd_chk(4'd6, 16'h0001, "R5");
        rd_chk(4'd7, 16'h2024, "R5");

        // R5 leap and non-leap Februaries, 30-day month, century wraps
        set_time(16'h2024, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd5, 16'h0029, "R5");
        rd_chk(4'd6, 16'h0002, "R5");
        set_time(16'h2024, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd5, 16'h0001, "R5");
        rd_chk(4'd6, 16'h0003, "R5");
        set_time(16'h2023, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd5, 16'h0001, "R5");
        rd_chk(4'd6, 16'h0003, "R5");
        set_time(16'h2023, 8'h04, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd5, 16'h0001, "R5");
        rd_chk(4'd6, 16'h0005, "R5");
        set_time(16'h2099, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd7, 16'h2100, "R5");
        set_time(16'h9999, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        run_secs(1);
        rd_chk(4'd7, 16'h0000, "R5");
        rd_chk(4'd4, 16'h0006, "R4");

        // R6 stopped clock holds, enable bit reads back
        idle(3 * PER);
        rd_chk(4'd1, 16'h0000, "R6");
        rd_chk(4'd9, 16'h0008, "R6");

        // R12 illegal BCD stored as written
        wr(4'd1, 16'h005C);
        rd_chk(4'd1, 16'h005C, "R12");
        wr(4'd6, 16'h001F);
        rd_chk(4'd6, 16'h001F, "R12");

        // R9 adjustment below and above 30 seconds
        set_time(16'h2022, 8'h06, 8'h15, 8'h03, 8'h10, 8'h10, 8'h25);
        wr(4'd9, 16'h0004);
        rd_chk(4'd1, 16'h0000, "R9");
        rd_chk(4'd2, 16'h0010, "R9");
        rd_chk(4'd9, 16'h0000, "R9 R6");
        wr(4'd1, 16'h0045);
        wr(4'd2, 16'h0059);
        wr(4'd3, 16'h0013);
        wr(4'd9, 16'h0004);
        rd_chk(4'd1, 16'h0000, "R9");
        rd_chk(4'd2, 16'h0000, "R9");
        rd_chk(4'd3, 16'h0014, "R9");

        // R10 R11 carry flag and interrupt
        wr(4'd8, 16'h0010);
        rd_chk(4'd8, 16'h0010, "R10");
        irq_chk(1'b0, "R11");
        run_secs(1);
        rd_chk(4'd8, 16'h0090, "R10");
        irq_chk(1'b1, "R11");
        wr(4'd8, 16'h0090);
        rd_chk(4'd8, 16'h0090, "R10");
        wr(4'd8, 16'h0080);
        rd_chk(4'd8, 16'h0080, "R10");
        irq_chk(1'b0, "R11");
        wr(4'd8, 16'h0010);
        rd_chk(4'd8, 16'h0010, "R10");

        // R10 a clearing write on the same edge as a seconds advance
        wr(4'd9, 16'h0002);
        wr(4'd9, 16'h0001);
        idle(PER - 2);
        wr(4'd8, 16'h0010);
        wr(4'd9, 16'h0000);
        rd_chk(4'd8, 16'h0090, "R10");

        // R7 prescaler clear in mid-second while running
        wr(4'd9, 16'h0001);
        idle(3);
        wr(4'd9, 16'h0003);
        rd_chk(4'd0, 16'h0000, "R7");
        idle(2 * PER);
        wr(4'd9, 16'h0000);
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule